// File: doc/BRIEF.md
# SPI Mode 3 Byte-Exchange Slave

This block is the slave side of an SPI link that runs with the serial clock idling high. Data leaves on falling edges and is captured on rising edges. Serial clock, MOSI and the active-low chip select come in asynchronously. Each one passes through a two-stage synchronizer into the system clock domain, and edge detection and bit counting are done there. The system clock must run at least four times faster than the serial clock.

Each time eight bits have arrived, the block presents the received byte with a one-cycle valid strobe. The byte to return is handed over on a load port. A pending register holds it until the next reload point. Reload points are the start of a select window and every byte boundary inside one. The master can therefore keep clocking under a single select and exchange any number of bytes.

MISO is modelled as a data bit plus an output enable. The enable is high only while the synchronized select is active.

Top module: `spi3_slave`

## Requirements
- R1: `miso_oe_o` is 0 whenever the chip select (`csn_i`) is high. It rises within 4 system clocks after `csn_i` goes low and falls within 4 system clocks after `csn_i` goes high.
- R2: Once select is active, bit 7 of the loaded byte is on `miso_o` before the first falling serial clock edge.
- R3: The transmit byte leaves most significant bit first. The first falling edge of each byte keeps bit 7, and each later falling edge moves to the next lower bit.
- R4: On each rising edge the MOSI bit enters at bit 0 and the earlier bits move up. After the eighth rising edge, `rx_data_o` holds the byte with the first-received bit at bit 7, and `rx_valid_o` is high for exactly one clock.
- R5: While the master keeps clocking under one select, the transmit register reloads at each byte boundary. It takes the most recent `tx_data_i` loaded with `tx_load_i` since the previous reload.
- R6: If nothing was loaded since the previous reload, the next byte sent is the idle fill 0x00.
- R7: Releasing select in the middle of a byte discards the partial byte and raises no valid strobe. The next select window starts a fresh byte.
- R8: Serial clock edges while select is inactive receive nothing and raise no valid strobe.
- R9: After reset, `miso_oe_o` and `rx_valid_o` are 0 and `rx_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, idles high |
| mosi_i | input | 1 | Serial data from the master |
| csn_i | input | 1 | Active-low chip select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | MISO output enable (0 = high impedance) |
| tx_data_i | input | 8 | Next byte to send |
| tx_load_i | input | 1 | Strobe that captures `tx_data_i` |
| rx_data_o | output | 8 | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |

## Verification
A table of byte pairs is run back to back under one select. The pairs are alternating bits, all ones against all zeros, a single set bit at either end, and mirrored patterns. Together they show whether either direction is bit-reversed, bit-shifted or stuck, and whether the reload at each boundary takes the right byte. Directed cases then cover these situations:
- a byte with nothing loaded, which must return the idle fill;
- two loads within one byte, where the later one must win;
- a half-clocked byte with select dropped, which must leave no strobe and no offset in the following byte;
- clocking with select inactive, which must be ignored and must leave MISO released.

// File: rtl/spi3_pkg.sv
package spi3_pkg;

  // Events derived from the synchronized serial inputs, one system clock wide.
  typedef struct packed {
    logic sclk_rise;
    logic sclk_fall;
    logic sel;
    logic sel_start;
  } spi3_evt_t;

endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{RST_VAL}};
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/spi3_edge.sv
module spi3_edge
  import spi3_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_s,
  input  logic      csn_s,
  output spi3_evt_t evt
);
  logic sclk_d;
  logic sel_d;
  logic sel;

  assign sel = ~csn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      sel_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= sel;
    end
  end

  assign evt.sel       = sel;
  assign evt.sel_start = sel & ~sel_d;
  assign evt.sclk_rise = sel & sclk_s & ~sclk_d;
  assign evt.sclk_fall = sel & ~sclk_s & sclk_d;
endmodule

// File: rtl/spi3_shift.sv
module spi3_shift
  import spi3_pkg::*;
#(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] IDLE_FILL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  spi3_evt_t     evt,
  input  logic          mosi_s,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_load,
  output logic          miso,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          byte_done
);
  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_sr;
  logic [DW-1:0] tx_sr;
  logic [DW-1:0] pend;
  logic          pend_vld;
  logic [DW-1:0] next_tx;
  logic [DW-1:0] rx_next;
  logic          reload;

  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] sr, input logic b);
    return {sr[DW-2:0], b};
  endfunction

  function automatic logic [DW-1:0] pick_next(input logic ld, input logic [DW-1:0] din,
                                              input logic pv, input logic [DW-1:0] pd);
    if (ld)      return din;
    else if (pv) return pd;
    else         return IDLE_FILL;
  endfunction

  assign rx_next   = shift_in(rx_sr, mosi_s);
  assign next_tx   = pick_next(tx_load, tx_data, pend_vld, pend);
  assign byte_done = evt.sel && !evt.sel_start && evt.sclk_rise && (bit_cnt == LAST_BIT);
  assign reload    = evt.sel_start || byte_done;
  assign miso      = tx_sr[DW-1];

  // Pending transmit byte: a reload consumes it, otherwise a load replaces it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      pend_vld <= 1'b0;
    end else if (reload) begin
      pend_vld <= 1'b0;
    end else if (tx_load) begin
      pend     <= tx_data;
      pend_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!evt.sel) begin
        bit_cnt <= '0;
        rx_sr   <= '0;
      end else if (evt.sel_start) begin
        bit_cnt <= '0;
        tx_sr   <= next_tx;
      end else if (evt.sclk_rise) begin
        rx_sr <= rx_next;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt  <= '0;
          rx_data  <= rx_next;
          rx_valid <= 1'b1;
          tx_sr    <= next_tx;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (evt.sclk_fall && bit_cnt != '0) begin
        tx_sr <= {tx_sr[DW-2:0], 1'b0};
      end
    end
  end

  // R7: an inactive select leaves the bit counter at zero.
  assert_count_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.sel |=> bit_cnt == '0);

  // R4: the valid strobe lasts a single clock.
  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4: a strobe only follows the last rising edge of a byte.
  assert_valid_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(evt.sclk_rise && bit_cnt == LAST_BIT));

  // R6: a boundary with nothing loaded picks up the idle fill.
  assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !pend_vld && !tx_load) |=> tx_sr == IDLE_FILL);

  // R3: the outgoing bit only changes on a falling edge or a reload.
  assert_miso_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.sel && $past(evt.sel) && !$past(evt.sclk_fall) && !$past(reload))
      |-> $stable(miso));
endmodule

// File: rtl/spi3_slave.sv
module spi3_slave
  import spi3_pkg::*;
#(
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-1:0] IDLE_FILL   = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          mosi_i,
  input  logic          csn_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_load_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o
);
  localparam int NSYNC = 3;
  // Reset levels per line: index 0 serial clock (idle high), 1 MOSI, 2 select (inactive high).
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b101;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] sync_out;
  spi3_evt_t        evt;
  logic             byte_done;

  assign raw_in = {csn_i, mosi_i, sclk_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    spi3_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in[g]),
      .q    (sync_out[g])
    );
  end

  spi3_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk_s(sync_out[0]),
    .csn_s (sync_out[2]),
    .evt   (evt)
  );

  spi3_shift #(.DW(DW), .IDLE_FILL(IDLE_FILL)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .mosi_s   (sync_out[1]),
    .tx_data  (tx_data_i),
    .tx_load  (tx_load_i),
    .miso     (miso_o),
    .rx_data  (rx_data_o),
    .rx_valid (rx_valid_o),
    .byte_done(byte_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miso_oe_o <= 1'b0;
    else        miso_oe_o <= evt.sel;
  end

  // R1: the enable only rises one clock after a select start.
  assert_oe_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe_o) |-> $past(evt.sel_start));

  // R1: the enable drops one clock after select is released.
  assert_oe_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt.sel) |=> !miso_oe_o);

  // R5: a completed byte is followed by a strobe in the next clock.
  assert_done_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rx_valid_o);
endmodule

// File: tb/tb_spi3_slave.sv
module tb_spi3_slave;
  localparam int HALF = 8;   // system clocks per serial half period
  localparam int NV   = 6;
  // Each entry: {byte the master sends, byte the slave is loaded with}
  localparam logic [15:0] VEC [NV] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00,
                                       16'h81_7E, 16'h5A_C3, 16'h01_80};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b1, mosi = 1'b0, csn = 1'b1;
  logic       miso, miso_oe;
  logic [7:0] tx_data = '0;
  logic       tx_load = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;

  int nchk = 0, nfail = 0, vcount = 0;
  logic [7:0] last_rx = '0;

  always #2 clk = ~clk;

  spi3_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .csn_i(csn),
    .miso_o(miso), .miso_oe_o(miso_oe), .tx_data_i(tx_data), .tx_load_i(tx_load),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) if (rx_valid) begin
    vcount++;
    last_rx = rx_data;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  // Master clocks n bits of mo (MSB first) and collects what MISO showed before each rise.
  task automatic clock_bits(input int n, input logic [7:0] mo, output logic [7:0] mi);
    mi = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; mosi = mo[7-i];
      repeat (HALF) @(negedge clk);
      mi[7-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic select(input logic on);
    csn = ~on;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int vbase;
    repeat (3) @(negedge clk);
    check("R9 oe", miso_oe, 0);
    check("R9 valid", rx_valid, 0);
    check("R9 rx_data", rx_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 oe while deselected", miso_oe, 0);

    // Table walk: all entries exchanged under one select.
    load(VEC[0][7:0]);
    select(1'b1);
    check("R1 oe after select", miso_oe, 1);
    check("R2 msb before first fall", miso, VEC[0][7]);
    for (int k = 0; k < NV; k++) begin
      vbase = vcount;
      if (k < NV - 1) load(VEC[k+1][7:0]);
      clock_bits(8, VEC[k][15:8], got);
      check("R3 R5 miso byte", got, VEC[k][7:0]);
      check("R4 rx byte", last_rx, VEC[k][15:8]);
      check("R4 one strobe", vcount - vbase, 1);
    end

    // Nothing loaded: idle fill.
    clock_bits(8, 8'h3A, got);
    check("R6 idle fill", got, 8'h00);
    // Two loads within one byte: later wins.
    load(8'h11);
    load(8'h99);
    clock_bits(8, 8'hC6, got);
    check("R6 fill while loading", got, 8'h00);
    clock_bits(8, 8'h24, got);
    check("R5 latest load wins", got, 8'h99);
    check("R4 rx after reload", last_rx, 8'h24);
    select(1'b0);
    check("R1 oe released", miso_oe, 0);

    // Abort mid-byte.
    vbase = vcount;
    load(8'h3C);
    select(1'b1);
    clock_bits(4, 8'hF0, got);
    select(1'b0);
    check("R7 no strobe on abort", vcount - vbase, 0);
    load(8'hE1);
    select(1'b1);
    check("R2 msb after abort", miso, 1);
    clock_bits(8, 8'h96, got);
    check("R7 fresh rx byte", last_rx, 8'h96);
    check("R7 fresh tx byte", got, 8'hE1);
    check("R7 one strobe", vcount - vbase, 1);
    select(1'b0);

    // Clocking while deselected.
    vbase = vcount;
    clock_bits(8, 8'h5F, got);
    check("R8 no strobe", vcount - vbase, 0);
    check("R8 rx unchanged", last_rx, 8'h96);
    check("R8 oe stays low", miso_oe, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule